// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits on the master side of a pipelined system bus. It turns one burst request (start address, burst code, transfer size) into the address-phase stream for every beat. For each beat it drives a two-bit transfer type and an address. The first beat is a non-sequential transfer. Each later beat is a sequential transfer whose address is derived from the beat before it. Incrementing bursts step by the transfer size. Wrapping bursts stay inside an aligned window whose size is the beat count times the transfer size.

A data source that cannot keep up raises a stall input. The sequencer then puts BUSY cycles on the bus, and during them the address already shows the next beat. The bus ready input gates every change. While it is low, the address and type stay frozen. A burst of undefined length runs until a stop input is seen on an accepted beat. A one-cycle done pulse marks the end of each burst.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the transfer type is IDLE (code 00) and `burstDone` is low. `startReady` is high whenever the sequencer is idle and `busReady` is high.
- R2: `startReady` is high only while the type is IDLE and `busReady` is high. A start accepted on a clock edge makes the next cycle show NONSEQ (code 10) at `startAddr`, whatever the state of `srcStall`. While a burst is running, `startValid` has no effect.
- R3: Each beat after the first uses SEQ (code 11). In an incrementing burst its address is the previous beat's address plus 2^`sizeCode` bytes.
- R4: In a wrapping burst the address stays inside the window aligned to (beats × 2^`sizeCode`) bytes and wraps to the window's low end. For example, a 4-beat 4-byte wrap from 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R5: Burst codes map as follows: 000 single (1 beat), 001 undefined-length increment, 010/011 4-beat wrap/increment, 100/101 8-beat wrap/increment, 110/111 16-beat wrap/increment. A fixed-length burst ends after exactly that many accepted beats.
- R6: If `srcStall` is high when a non-final beat is accepted, the next cycle shows BUSY (code 01) with the next beat's address. BUSY repeats while `srcStall` stays high on ready cycles, and SEQ follows at that same address once it is low.
- R7: While `busReady` is low, `transType` and `busAddr` keep their values.
- R8: An undefined-length burst ends on the beat that is accepted with `stopReq` high. `stopReq` has no effect at any other time and in fixed-length bursts.
- R9: One cycle after the final beat is accepted, `burstDone` is high for exactly one cycle and the type is IDLE.
- R10: A single transfer shows one NONSEQ beat and then returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Burst request valid |
| startReady | output | 1 | Request can be taken this cycle |
| startAddr | input | ADDR_W | First beat address |
| burstCode | input | 3 | Burst kind and length |
| sizeCode | input | 3 | log2 of bytes per beat |
| srcStall | input | 1 | Data source not ready; insert BUSY |
| stopReq | input | 1 | Ends an undefined-length burst |
| busReady | input | 1 | Bus accepts the current address phase |
| transType | output | 2 | 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| busAddr | output | ADDR_W | Address of current or next beat |
| burstDone | output | 1 | One-cycle pulse after the final beat |

## Verification
Some properties are checked on every cycle. Type and address hold while ready is low. A request taken while idle leads to NONSEQ. The done pulse lasts one cycle and lands in IDLE. BUSY never follows IDLE. A wrapping burst never leaves its aligned window. The exact address order needs the bench scenarios, which compare each beat against an address computed from the beat index. The same holds for beat counts per code, stop handling in undefined bursts, and where BUSY cycles fall under random stalls and waits.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  // strobes from control to address datapath
  typedef struct packed {
    logic loadStart;
    logic stepAddr;
  } dpStrobe_t;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int MAX_BEATS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic [2:0] burstCode,
  input  logic       srcStall,
  input  logic       stopReq,
  input  logic       busReady,
  output logic       startReady,
  output trans_e     transType,
  output logic       burstDone,
  output dpStrobe_t  strobe
);
  localparam int CNT_W = $clog2(MAX_BEATS + 1);

  trans_e           typeQ;
  logic [CNT_W-1:0] beatsLeftQ;
  logic             undefQ;
  logic             doneQ;
  logic             acceptBeat;
  logic             lastBeat;
  logic [CNT_W-1:0] beatsInit;

  always_comb begin
    if (burstCode[2:1] == 2'b00) beatsInit = CNT_W'(1);
    else beatsInit = CNT_W'(1) << ({1'b0, burstCode[2:1]} + 3'd1);
  end

  assign acceptBeat = busReady && (typeQ == TR_NONSEQ || typeQ == TR_SEQ);
  assign lastBeat   = undefQ ? stopReq : (beatsLeftQ == CNT_W'(1));
  assign startReady = (typeQ == TR_IDLE) && busReady;
  assign strobe.loadStart = startReady && startValid;
  assign strobe.stepAddr  = acceptBeat && !lastBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ      <= TR_IDLE;
      beatsLeftQ <= '0;
      undefQ     <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= acceptBeat && lastBeat;
      if (strobe.loadStart) begin
        typeQ      <= TR_NONSEQ;
        beatsLeftQ <= beatsInit;
        undefQ     <= (burstCode == 3'b001);
      end else if (acceptBeat) begin
        if (lastBeat) typeQ <= TR_IDLE;
        else typeQ <= srcStall ? TR_BUSY : TR_SEQ;
        if (!undefQ) beatsLeftQ <= beatsLeftQ - CNT_W'(1);
      end else if (busReady && typeQ == TR_BUSY) begin
        typeQ <= srcStall ? TR_BUSY : TR_SEQ;
      end
    end
  end

  assign transType = typeQ;
  assign burstDone = doneQ;

  // R2: a request taken while idle is followed by a NONSEQ beat
  assert_start_nonseq_R2: assert property (@(posedge clk) disable iff (!rstN)
    (transType == TR_IDLE && busReady && startValid) |=> transType == TR_NONSEQ);
  // R7: type frozen while the bus waits
  assert_wait_hold_type_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |=> $stable(transType));
  // R9: done is a single-cycle pulse landing in IDLE
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> (transType == TR_IDLE) ##1 !burstDone);
  // R6: BUSY only appears inside a burst
  assert_busy_midburst_R6: assert property (@(posedge clk) disable iff (!rstN)
    (transType == TR_BUSY) |-> $past(transType) != TR_IDLE);
endmodule

// File: rtl/bseq_addr_dp.sv
module bseq_addr_dp
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        burstCode,
  input  logic [2:0]        sizeCode,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] startQ;
  logic [2:0]        sizeQ;
  logic [2:0]        beatsLogQ;
  logic              wrapQ;
  logic [3:0]        boundLog;
  logic [ADDR_W-1:0] wrapMask;
  logic [ADDR_W-1:0] stepBytes;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] nextAddr;

  assign boundLog  = {1'b0, sizeQ} + {1'b0, beatsLogQ};
  assign wrapMask  = (ADDR_W'(1) << boundLog) - ADDR_W'(1);
  assign stepBytes = ADDR_W'(1) << sizeQ;
  assign incAddr   = addrQ + stepBytes;
  assign nextAddr  = wrapQ ? ((addrQ & ~wrapMask) | (incAddr & wrapMask)) : incAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      startQ    <= '0;
      sizeQ     <= '0;
      beatsLogQ <= '0;
      wrapQ     <= 1'b0;
    end else if (strobe.loadStart) begin
      addrQ     <= startAddr;
      startQ    <= startAddr;
      sizeQ     <= sizeCode;
      beatsLogQ <= {1'b0, burstCode[2:1]} + 3'd1;
      wrapQ     <= !burstCode[0] && (burstCode[2:1] != 2'b00);
    end else if (strobe.stepAddr) begin
      addrQ <= nextAddr;
    end
  end

  assign busAddr = addrQ;

  // R7: address frozen while the bus waits
  assert_wait_hold_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |=> $stable(busAddr));
  // R4: a wrapping burst never leaves its aligned window
  assert_wrap_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrapQ |-> ((busAddr ^ startQ) & ~wrapMask) == '0);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  output logic              startReady,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        burstCode,
  input  logic [2:0]        sizeCode,
  input  logic              srcStall,
  input  logic              stopReq,
  input  logic              busReady,
  output logic [1:0]        transType,
  output logic [ADDR_W-1:0] busAddr,
  output logic              burstDone
);
  dpStrobe_t strobe;
  trans_e    typeInt;

  bseq_ctrl #(.MAX_BEATS(MAX_BEATS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .burstCode(burstCode),
    .srcStall(srcStall), .stopReq(stopReq), .busReady(busReady),
    .startReady(startReady), .transType(typeInt), .burstDone(burstDone),
    .strobe(strobe)
  );

  bseq_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .burstCode(burstCode), .sizeCode(sizeCode), .busReady(busReady),
    .busAddr(busAddr)
  );

  assign transType = typeInt;
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        startValid, startReady, srcStall, stopReq, busReady, burstDone;
  logic [31:0] startAddr, busAddr;
  logic [2:0]  burstCode, sizeCode;
  logic [1:0]  transType;
  int nTests = 0;
  int nFail  = 0;

  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;

  always #2.5 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .startAddr(startAddr), .burstCode(burstCode), .sizeCode(sizeCode),
    .srcStall(srcStall), .stopReq(stopReq), .busReady(busReady),
    .transType(transType), .busAddr(busAddr), .burstDone(burstDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int beatsOf(input logic [2:0] code);
    return (code[2:1] == 2'b00) ? 1 : (1 << (code[2:1] + 1));
  endfunction

  function automatic logic [31:0] beatAddr(input logic [31:0] s, input logic [2:0] code,
                                           input logic [2:0] sz, input int i);
    int unsigned bytes = 1 << sz;
    if (!code[0] && code[2:1] != 2'b00) begin
      int unsigned bound = bytes * beatsOf(code);
      logic [31:0] base = s - (s % bound);
      return base + ((s - base + i * bytes) % bound);
    end
    return s + i * bytes;
  endfunction

  task automatic runBurst(input logic [31:0] s, input logic [2:0] code, input logic [2:0] sz,
                          input int stopAt, input int stallPct, input int waitPct);
    bit isWrap = !code[0] && code[2:1] != 2'b00;
    bit undef  = (code == 3'b001);
    int total  = undef ? stopAt : beatsOf(code);
    int i = 0;
    bit finished = 0;
    bit held = 0;
    logic [1:0]  expType = T_NSEQ;
    logic [31:0] expAddr = s;
    busReady = 1'b1; srcStall = 1'b0; stopReq = 1'b0;
    #0.1;
    check(startReady === 1'b1 && transType === T_IDLE, "R2", "startReady when idle", startReady, 1);
    startValid = 1'b1; startAddr = s; burstCode = code; sizeCode = sz;
    srcStall = $urandom % 2;  // ignored on the first beat
    @(negedge clk);
    while (!finished) begin
      bit rdy, stall, acc, last;
      string rq = held ? "R7" : (expType == T_NSEQ) ? ((code == 3'b000) ? "R10" : "R2")
                : (expType == T_BUSY) ? "R6" : "R3";
      check(transType === expType, rq, "transfer type", transType, expType);
      check(busAddr === expAddr, held ? "R7" : (isWrap ? "R4" : "R3"), "beat address", busAddr, expAddr);
      check(burstDone === 1'b0 && startReady === 1'b0, "R9", "no done mid-burst",
            {burstDone, startReady}, 0);
      rdy   = ($urandom % 100) >= waitPct;
      stall = ($urandom % 100) < stallPct;
      acc   = rdy && (expType == T_NSEQ || expType == T_SEQ);
      last  = acc && (i == total - 1);
      if (undef) stopReq = acc ? last : ($urandom % 2);
      else stopReq = $urandom % 2;  // R8: ignored for fixed bursts
      busReady = rdy; srcStall = stall;
      startValid = $urandom % 2; startAddr = $urandom;  // R2: ignored while busy
      @(negedge clk);
      held = !rdy;
      if (acc) begin
        if (last) finished = 1;
        else begin
          i++;
          expAddr = beatAddr(s, code, sz, i);
          expType = stall ? T_BUSY : T_SEQ;
        end
      end else if (rdy) begin
        expType = stall ? T_BUSY : T_SEQ;
      end
    end
    check(transType === T_IDLE && burstDone === 1'b1, undef ? "R8" : "R5",
          "end after expected beat count", {transType, burstDone}, {T_IDLE, 1'b1});
    startValid = 1'b0; busReady = 1'b1; stopReq = 1'b0; srcStall = 1'b0;
    @(negedge clk);
    check(burstDone === 1'b0, "R9", "done lasts one cycle", burstDone, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run timed out", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; startValid = 1'b0; startAddr = '0; burstCode = '0; sizeCode = '0;
    srcStall = 1'b0; stopReq = 1'b0; busReady = 1'b1;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(transType === T_IDLE && burstDone === 1'b0, "R1", "reset outputs", {transType, burstDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(startReady === 1'b1, "R1", "ready after reset", startReady, 1);
    // directed corner cases
    runBurst(32'h34, 3'b010, 3'd2, 0, 0, 0);     // R4 wrap example
    runBurst(32'h34, 3'b010, 3'd2, 0, 50, 30);   // R4 with stalls and waits
    runBurst(32'h100, 3'b000, 3'd2, 0, 50, 50);  // R10 single
    runBurst(32'h200, 3'b001, 3'd0, 5, 30, 20);  // R8 undefined length
    runBurst(32'h40, 3'b001, 3'd1, 1, 0, 0);     // R8 stop on first beat
    runBurst(32'h1006, 3'b101, 3'd1, 0, 0, 60);  // R7 heavy waits
    runBurst(32'h1007, 3'b110, 3'd0, 0, 60, 0);  // R6 heavy stalls, byte wrap16
    runBurst(32'h3F8, 3'b111, 3'd3, 0, 20, 20);  // R3 incr16 doublewords
    // constrained random bursts
    for (int n = 0; n < 60; n++) begin
      logic [2:0]  c  = $urandom % 8;
      logic [2:0]  sz = $urandom % 4;
      logic [31:0] a  = ($urandom % 32'h10000) & ~((32'd1 << sz) - 1);
      runBurst(a, c, sz, 1 + ($urandom % 8), $urandom % 40, $urandom % 40);
    end
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule